// File: doc/BRIEF.md
# Call-Progress and Keypad Tone Sequencer with PWM Output

The block steps through a fixed script of telephone tone pairs and feeds the pairs to an external dual-tone oscillator. The script is dial tone, ringback, busy, then the keypad digits 0 to 9 in ascending order. Each pair is presented as two frequency words in millihertz together with a one-cycle load strobe. A pair is held for a programmable number of sample ticks. A silent interval follows, in which both words are zero, and then the next pair starts. After the last digit the script returns to dial tone and runs again without end.

The same block contains the output stage. The oscillator hands over a duty word once per sample, and the block turns it into a pulse train on one pin. At each sample tick the compare register takes the duty word that was computed during the tick before, and the pulse counter restarts at zero. The pin is high from count zero until the count reaches the compare value. This costs one sample of latency between the oscillator and the pin, and in return the edge position is stable for a whole sample period.

Top module: `tone_seq_pwm`

## Requirements
- R1: While reset is low and until the first clock edge after it is released, tone_a_mhz = 350000, tone_b_mhz = 440000 and tone_load = 1. The PWM compare is 180 and the PWM counter is 0, so pwm_out = 1.
- R2: The script order is entry 0 dial (350000, 440000), entry 1 ring (440000, 480000), entry 2 busy (480000, 620000), then entries 3 to 12 for digits 0 to 9. After entry 12 comes entry 0.
- R3: Digit frequency pairs in mHz (low, high) are as follows. Digit 0 is (941000, 1336000). Digits 1, 2, 3 use low 697000. Digits 4, 5, 6 use low 770000. Digits 7, 8, 9 use low 852000. Within each group of three the high word is 1209000, then 1336000, then 1477000.
- R4: A pair is output for exactly TONE_TICKS sample ticks. Both words are then 0 for exactly GAP_TICKS sample ticks. Every change of the words is registered on the clock edge that samples the tick ending the interval.
- R5: tone_load is high for exactly one cycle after each change of the frequency words, and is low in every other cycle after the reset release.
- R6: Clock cycles without sample_tick leave the frequency words and the cadence position unchanged.
- R7: The PWM counter counts 0 to PWM_PERIOD-1 and wraps. A sample tick forces it to 0. pwm_out is high exactly while the counter is below the compare value.
- R8: The compare value loads duty_word only on a clock edge with sample_tick high. Changes of duty_word between ticks have no effect on pwm_out.
- R9: A compare value of PWM_PERIOD or more keeps pwm_out high for the whole period. A compare value of 0 keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the PWM counter and all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle strobe marking the start of each audio sample |
| duty_word | input | DUTY_W | Duty value computed by the oscillator for the current sample |
| tone_a_mhz | output | 24 | Low tone frequency in mHz, 0 during silence |
| tone_b_mhz | output | 24 | High tone frequency in mHz, 0 during silence |
| tone_load | output | 1 | Pulses for one cycle when the frequency words change |
| pwm_out | output | 1 | Pulse-width modulated audio output |

## Verification
Several properties are checked on every clock cycle. The load strobe always drops after one cycle and never rises without a tick. The frequency words hold between ticks, and the two words are zero together. The compare register takes the previous cycle's duty word on a tick, the PWM counter stays within its period, and a saturated compare keeps the pin high. Other behaviour can only be shown by the bench's scenarios, which run against a behavioural model. These are the exact script order including the wrap back to dial tone, the tick counts between loads, and the number of high cycles a given duty produces over a period. The same applies to the proof that a duty word changed between ticks never reaches the pin.

// File: rtl/tone_seq_pkg.sv
package tone_seq_pkg;

  localparam int FREQ_W      = 24;
  localparam int NUM_ENTRIES = 13;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);

  typedef logic [FREQ_W-1:0] freq_t;

  typedef struct packed {
    freq_t low;
    freq_t high;
  } tone_pair_t;

  typedef enum logic {
    PH_TONE = 1'b0,
    PH_GAP  = 1'b1
  } cadence_ph_e;

  // Script entry to frequency pair, millihertz
  function automatic tone_pair_t script_pair(input logic [IDX_W-1:0] idx);
    tone_pair_t p;
    case (idx)
      4'd0:    p = '{low: 24'd350000, high: 24'd440000};
      4'd1:    p = '{low: 24'd440000, high: 24'd480000};
      4'd2:    p = '{low: 24'd480000, high: 24'd620000};
      4'd3:    p = '{low: 24'd941000, high: 24'd1336000};
      4'd4:    p = '{low: 24'd697000, high: 24'd1209000};
      4'd5:    p = '{low: 24'd697000, high: 24'd1336000};
      4'd6:    p = '{low: 24'd697000, high: 24'd1477000};
      4'd7:    p = '{low: 24'd770000, high: 24'd1209000};
      4'd8:    p = '{low: 24'd770000, high: 24'd1336000};
      4'd9:    p = '{low: 24'd770000, high: 24'd1477000};
      4'd10:   p = '{low: 24'd852000, high: 24'd1209000};
      4'd11:   p = '{low: 24'd852000, high: 24'd1336000};
      4'd12:   p = '{low: 24'd852000, high: 24'd1477000};
      default: p = '{low: '0, high: '0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/tone_cadence.sv
module tone_cadence
  import tone_seq_pkg::*;
#(
  parameter int TONE_TICKS = 32000,
  parameter int GAP_TICKS  = 16000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [IDX_W-1:0]  idx,
  output cadence_ph_e       phase,
  output logic              load
);

  localparam int MAX_TICKS = (TONE_TICKS > GAP_TICKS) ? TONE_TICKS : GAP_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int LAST_IDX  = NUM_ENTRIES - 1;

  logic [IDX_W-1:0] idx_q, idx_d;
  cadence_ph_e      ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load_q, load_d;
  logic             adv_en;

  assign adv_en = tick;

  // next-state
  always_comb begin
    idx_d  = idx_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    load_d = 1'b0;
    if (adv_en) begin
      if (cnt_q == CNT_W'(1)) begin
        load_d = 1'b1;
        if (ph_q == PH_TONE) begin
          ph_d  = PH_GAP;
          cnt_d = CNT_W'(GAP_TICKS);
        end else begin
          ph_d  = PH_TONE;
          cnt_d = CNT_W'(TONE_TICKS);
          idx_d = (idx_q == IDX_W'(LAST_IDX)) ? '0 : idx_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  // state registers, enabled by the sample tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_TONE;
      cnt_q <= CNT_W'(TONE_TICKS);
    end else if (adv_en) begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  // load strobe, set out of reset so the first pair is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b1;
    end else begin
      load_q <= load_d;
    end
  end

  assign idx   = idx_q;
  assign phase = ph_q;
  assign load  = load_q;

endmodule

// File: rtl/tone_pair_rom.sv
module tone_pair_rom
  import tone_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  cadence_ph_e      phase,
  output tone_pair_t       pair
);

  always_comb begin
    if (phase == PH_GAP) begin
      pair = '{low: '0, high: '0};
    end else begin
      pair = script_pair(idx);
    end
  end

endmodule

// File: rtl/pwm_stage.sv
module pwm_stage #(
  parameter int PERIOD     = 320,
  parameter int DUTY_W     = 16,
  parameter int RESET_DUTY = 180
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic [DUTY_W-1:0]         duty,
  output logic                      pwm,
  output logic [DUTY_W-1:0]         cmp_o,
  output logic [$clog2(PERIOD)-1:0] cnt_o
);

  localparam int PCNT_W = $clog2(PERIOD);
  localparam int CMP_W  = (DUTY_W > PCNT_W) ? DUTY_W : PCNT_W;

  logic [PCNT_W-1:0] cnt_q, cnt_d;
  logic [DUTY_W-1:0] cmp_q;
  logic              cmp_en;
  logic [CMP_W-1:0]  cnt_ext, cmp_ext;

  assign cmp_en = tick;

  always_comb begin
    if (tick) begin
      cnt_d = '0;
    end else if (cnt_q == PCNT_W'(PERIOD - 1)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // compare takes the sample finished during the previous tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= DUTY_W'(RESET_DUTY);
    end else if (cmp_en) begin
      cmp_q <= duty;
    end
  end

  // set at count 0, reset at the compare value
  assign cnt_ext = CMP_W'(cnt_q);
  assign cmp_ext = CMP_W'(cmp_q);
  assign pwm     = (cnt_ext < cmp_ext);

  assign cmp_o = cmp_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/tone_seq_pwm.sv
module tone_seq_pwm
  import tone_seq_pkg::*;
#(
  parameter int TONE_TICKS = 32000,
  parameter int GAP_TICKS  = 16000,
  parameter int PWM_PERIOD = 320,
  parameter int DUTY_W     = 16,
  parameter int RESET_DUTY = 180
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sample_tick,
  input  logic [DUTY_W-1:0]             duty_word,
  output logic [tone_seq_pkg::FREQ_W-1:0] tone_a_mhz,
  output logic [tone_seq_pkg::FREQ_W-1:0] tone_b_mhz,
  output logic                          tone_load,
  output logic                          pwm_out
);

  localparam int PCNT_W = $clog2(PWM_PERIOD);

  logic [IDX_W-1:0]  idx_w;
  cadence_ph_e       ph_w;
  tone_pair_t        pair_w;
  logic [DUTY_W-1:0] cmp_w;
  logic [PCNT_W-1:0] pcnt_w;

  tone_cadence #(
    .TONE_TICKS (TONE_TICKS),
    .GAP_TICKS  (GAP_TICKS)
  ) cadence_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sample_tick),
    .idx   (idx_w),
    .phase (ph_w),
    .load  (tone_load)
  );

  tone_pair_rom rom_i (
    .idx   (idx_w),
    .phase (ph_w),
    .pair  (pair_w)
  );

  pwm_stage #(
    .PERIOD     (PWM_PERIOD),
    .DUTY_W     (DUTY_W),
    .RESET_DUTY (RESET_DUTY)
  ) pwm_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sample_tick),
    .duty  (duty_word),
    .pwm   (pwm_out),
    .cmp_o (cmp_w),
    .cnt_o (pcnt_w)
  );

  assign tone_a_mhz = pair_w.low;
  assign tone_b_mhz = pair_w.high;

endmodule

// File: rtl/tone_seq_pwm_chk.sv
module tone_seq_pwm_chk #(
  parameter int PWM_PERIOD = 320,
  parameter int DUTY_W     = 16,
  parameter int PCNT_W     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_tick,
  input logic [DUTY_W-1:0] duty_word,
  input logic [23:0]       tone_a_mhz,
  input logic [23:0]       tone_b_mhz,
  input logic              tone_load,
  input logic              pwm_out,
  input logic [DUTY_W-1:0] cmp,
  input logic [PCNT_W-1:0] pcnt
);

  a_r5_load_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tone_load |=> !tone_load);

  a_r5_load_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> !tone_load);

  a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> ($stable(tone_a_mhz) && $stable(tone_b_mhz)));

  a_r4_silence_both: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_a_mhz == 24'd0) == (tone_b_mhz == 24'd0));

  a_r8_cmp_takes_duty: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> (cmp == $past(duty_word)));

  a_r8_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(cmp));

  a_r7_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> (pcnt == '0));

  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pcnt) < PWM_PERIOD);

  a_r9_saturated_high: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cmp) >= PWM_PERIOD) |-> pwm_out);

  a_r9_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0) |-> !pwm_out);

endmodule

bind tone_seq_pwm tone_seq_pwm_chk #(
  .PWM_PERIOD (PWM_PERIOD),
  .DUTY_W     (DUTY_W),
  .PCNT_W     (PCNT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_tick (sample_tick),
  .duty_word   (duty_word),
  .tone_a_mhz  (tone_a_mhz),
  .tone_b_mhz  (tone_b_mhz),
  .tone_load   (tone_load),
  .pwm_out     (pwm_out),
  .cmp         (cmp_w),
  .pcnt        (pcnt_w)
);

// File: tb/tone_seq_pwm_tb_top.sv
module tone_seq_pwm_tb_top;

  localparam int TT = 8;
  localparam int GT = 4;
  localparam int PP = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_tick = 1'b0;
  logic [DW-1:0] duty_word = '0;
  logic [23:0]   tone_a_mhz, tone_b_mhz;
  logic          tone_load, pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tone_seq_pwm #(
    .TONE_TICKS (TT),
    .GAP_TICKS  (GT),
    .PWM_PERIOD (PP),
    .DUTY_W     (DW),
    .RESET_DUTY (180)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .duty_word   (duty_word),
    .tone_a_mhz  (tone_a_mhz),
    .tone_b_mhz  (tone_b_mhz),
    .tone_load   (tone_load),
    .pwm_out     (pwm_out)
  );

  // expected script, written from R2 and R3
  int lo_tab [13] = '{350000, 440000, 480000, 941000, 697000, 697000, 697000,
                      770000, 770000, 770000, 852000, 852000, 852000};
  int hi_tab [13] = '{440000, 480000, 620000, 1336000, 1209000, 1336000, 1477000,
                      1209000, 1336000, 1477000, 1209000, 1336000, 1477000};

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  int m_idx, m_tone, m_left, m_load, m_pcnt, m_cmp;
  int tick_total = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_tone = 1; m_left = TT; m_load = 1; m_pcnt = 0; m_cmp = 180;
    end else begin
      m_load = 0;
      if (sample_tick) begin
        tick_total++;
        m_left--;
        if (m_left == 0) begin
          m_load = 1;
          if (m_tone == 1) begin
            m_tone = 0; m_left = GT;
          end else begin
            m_tone = 1; m_left = TT; m_idx = (m_idx + 1) % 13;
          end
        end
        m_pcnt = 0;
        m_cmp  = int'(duty_word);
      end else begin
        m_pcnt = (m_pcnt + 1) % PP;
      end
    end
  end

  // per-clock comparison and load-sequence monitor
  int seq_no = 1;
  int last_load_ticks = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tone_a_mhz == 24'(m_tone ? lo_tab[m_idx] : 0), "R2 low word", tone_a_mhz,
            m_tone ? lo_tab[m_idx] : 0);
      check(tone_b_mhz == 24'(m_tone ? hi_tab[m_idx] : 0), "R3 high word", tone_b_mhz,
            m_tone ? hi_tab[m_idx] : 0);
      check(tone_load == m_load[0], "R5 load strobe", tone_load, m_load);
      check(pwm_out == (m_pcnt < m_cmp), "R7 pwm level", pwm_out, (m_pcnt < m_cmp));
      if (tone_load) begin
        // odd loads start silence after a tone, even loads start the next tone
        if (seq_no % 2 == 1) begin
          check(tone_a_mhz == 0 && tone_b_mhz == 0, "R4 silence words", tone_a_mhz, 0);
          check(tick_total - last_load_ticks == TT, "R4 tone length", tick_total - last_load_ticks, TT);
        end else begin
          check(tone_a_mhz == 24'(lo_tab[(seq_no / 2) % 13]), "R2 order", tone_a_mhz,
                lo_tab[(seq_no / 2) % 13]);
          check(tick_total - last_load_ticks == GT, "R4 gap length", tick_total - last_load_ticks, GT);
        end
        last_load_ticks = tick_total;
        seq_no++;
      end
    end
  end

  task automatic send_tick(input int duty);
    @(negedge clk);
    sample_tick = 1'b1;
    duty_word   = DW'(duty);
    @(negedge clk);
    sample_tick = 1'b0;
  endtask

  // R8/R9: count high cycles over one period after a tick
  task automatic pwm_window(input int duty, input int disturb);
    int highs = 0;
    @(negedge clk);
    sample_tick = 1'b1;
    duty_word   = DW'(duty);
    @(negedge clk);
    sample_tick = 1'b0;
    duty_word   = DW'(disturb);
    for (int i = 0; i < PP; i++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
    check(highs == ((duty < PP) ? duty : PP), "R9 high count", highs, (duty < PP) ? duty : PP);
  endtask

  initial begin
    logic [23:0] hold_a, hold_b;
    int loads;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tone_a_mhz == 24'd350000, "R1 reset low", tone_a_mhz, 350000);
    check(tone_b_mhz == 24'd440000, "R1 reset high", tone_b_mhz, 440000);
    check(tone_load == 1'b1, "R1 reset load", tone_load, 1);
    check(pwm_out == 1'b1, "R1 reset pwm", pwm_out, 1);
    #2 rst_n = 1'b1;

    // two full passes of the script with varied duty
    for (int k = 0; k < 2 * 13 * (TT + GT) + 6; k++) begin
      send_tick((k * 7) % 14);
      repeat (10) @(negedge clk);
    end
    check(seq_no > 2 * 26, "R2 wrap reached", seq_no, 2 * 26);

    // R6: no ticks, nothing moves
    hold_a = tone_a_mhz;
    hold_b = tone_b_mhz;
    loads = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tone_load) loads++;
    end
    check(tone_a_mhz == hold_a && tone_b_mhz == hold_b, "R6 words held", tone_a_mhz, hold_a);
    check(loads == 0, "R6 no load", loads, 0);

    // R8 and R9 windows, duty disturbed between ticks
    pwm_window(3, 9);
    pwm_window(0, 7);
    pwm_window(400, 0);
    pwm_window(PP, 1);
    pwm_window(PP - 1, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule